// File: doc/BRIEF.md
# Character Display Raster Timing Generator

This block produces the raster timing for a character-cell display. It advances on a character-clock enable and produces active-high horizontal and vertical sync, a display-enable window, the current character row and scan line within that row, and a linear refresh address into a 1024-cell video RAM. The address stays the same for every scan line of a character row, so a character generator can use the scan counter to select the pixel line of each glyph.

The geometry comes from a small set of configuration registers, and reset loads the power-up values into them. The power-up line is 32 character times with 24 of them shown. The power-up frame has 32 rows of 8 scan lines each, plus one extra adjust line, and 27 of those rows are shown. Software can change any register through a byte-wide write port. A one-clock frame pulse marks the start of vertical sync, so it can serve as a once-per-frame interrupt.

Top module: `tmg_crt_timing`

## Requirements
- R1: While `rst` is high, all outputs are 0, the address is the start address, and the registers take their power-up values: line total 31, shown columns 24, hsync column 26, width byte 0x34, row total 31, adjust lines 1, shown rows 27, vsync row 28, last scan line 7, start address 0.
- R2: The column counter runs from 0 to the line total, then returns to 0. Every counter and every sync or enable output holds its value in any clock where `ce` is low.
- R3: `hsync_o` is high for the character times whose column is at least the hsync column and less than the hsync column plus the low nibble of the width byte. It appears one character time after that column. A width of 0 gives no hsync.
- R4: `de_o` is high one character time after a column below the shown-column count, within a row below the shown-row count, outside the adjust lines.
- R5: `scan_o` counts 0 up to the last-scan-line value. After the last scan line, `row_o` advances by one, and it wraps after the row total.
- R6: After the last scan line of the row-total row, the number of adjust lines in the register is added. During these lines `row_o` holds the row total and `scan_o` counts 0, 1, and so on. An adjust value of 0 sends the frame straight back to row 0.
- R7: At a line boundary where the next line is scan 0 of the vsync row (not an adjust line), `vsync_o` rises. It stays high for the number of lines in the high nibble of the width byte. A nibble of 0 gives no vsync.
- R8: `frame_o` is high for exactly one clock, in the clock where `vsync_o` rises.
- R9: `addr_o` = (start address + row × shown columns + column) mod 1024. It does not depend on the scan line.
- R10: A write with `reg_we` high loads `reg_wd` into a register selected by `reg_idx`, and the new value is in use from the next clock. The index map is: 0 line total, 1 shown columns, 2 hsync column, 3 width byte (bits 3:0 hsync, bits 7:4 vsync), 4 row total, 5 shown rows, 6 vsync row, 7 last scan line, 8 adjust lines, 9 start address bits 7:0, 10 start address bits 9:8 (from `reg_wd[1:0]`). Indices 11 to 15 change nothing.
- R11: If a limit is lowered below a counter's present value, that counter wraps at its next boundary instead of running on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Character-clock enable |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wd | input | 8 | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable, delayed one character time |
| frame_o | output | 1 | One-clock pulse when vertical sync begins |
| row_o | output | 7 | Current character row |
| scan_o | output | 5 | Scan line within the row (adjust line during the adjust phase) |
| addr_o | output | 10 | Refresh address into video RAM |

## Verification
The assertions assume that `ce` is a plain per-clock enable that may be high in any number of consecutive clocks. They also assume that a register write may fall in any clock, including clocks with `ce` high. That write acts only at the following edge. The stimulus draws `ce` at random with a fixed seed and writes a whole geometry while the raster runs, including one write that lowers the line total under the live column. It uses only the eleven defined register indices, plus directed writes to the spare indices.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  parameter int HCW = 8;   // column counter width
  parameter int RCW = 7;   // row counter width
  parameter int SCW = 5;   // scan-line counter width
  parameter int AW  = 10;  // refresh address width
  parameter int IW  = 4;   // register index width

  typedef struct packed {
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hdisp;
    logic [HCW-1:0] hpos;
    logic [3:0]     hwid;
    logic [3:0]     vwid;
    logic [RCW-1:0] vtot;
    logic [RCW-1:0] vdisp;
    logic [RCW-1:0] vpos;
    logic [SCW-1:0] maxsc;
    logic [SCW-1:0] vadj;
    logic [AW-1:0]  start;
  } tmg_cfg_t;

  // column inside [pos, pos+wid)
  function automatic logic in_window(input logic [HCW-1:0] col,
                                     input logic [HCW-1:0] pos,
                                     input logic [3:0] wid);
    logic [HCW:0] lim;
    lim = {1'b0, pos} + {{(HCW-3){1'b0}}, wid};
    return (col >= pos) && ({1'b0, col} < lim);
  endfunction

  function automatic logic [AW-1:0] refresh_addr(input logic [AW-1:0] start,
                                                 input logic [RCW-1:0] row,
                                                 input logic [HCW-1:0] hdisp,
                                                 input logic [HCW-1:0] col);
    logic [RCW+HCW-1:0] prod;
    prod = row * hdisp;
    return start + prod[AW-1:0] + AW'(col);
  endfunction
endpackage

// File: rtl/tmg_regs.sv
module tmg_regs
  import tmg_pkg::*;
#(
  parameter logic [7:0] D_HTOT  = 8'd31,
  parameter logic [7:0] D_HDISP = 8'd24,
  parameter logic [7:0] D_HPOS  = 8'd26,
  parameter logic [7:0] D_WID   = 8'h34,
  parameter logic [7:0] D_VTOT  = 8'd31,
  parameter logic [7:0] D_VDISP = 8'd27,
  parameter logic [7:0] D_VPOS  = 8'd28,
  parameter logic [7:0] D_MAXSC = 8'd7,
  parameter logic [7:0] D_VADJ  = 8'd1,
  parameter logic [9:0] D_START = 10'd0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wd,
  output tmg_cfg_t      cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.htot  <= HCW'(D_HTOT);
      cfg.hdisp <= HCW'(D_HDISP);
      cfg.hpos  <= HCW'(D_HPOS);
      cfg.hwid  <= D_WID[3:0];
      cfg.vwid  <= D_WID[7:4];
      cfg.vtot  <= RCW'(D_VTOT);
      cfg.vdisp <= RCW'(D_VDISP);
      cfg.vpos  <= RCW'(D_VPOS);
      cfg.maxsc <= SCW'(D_MAXSC);
      cfg.vadj  <= SCW'(D_VADJ);
      cfg.start <= AW'(D_START);
    end else if (we) begin
      case (idx)
        IW'(0):  cfg.htot  <= HCW'(wd);
        IW'(1):  cfg.hdisp <= HCW'(wd);
        IW'(2):  cfg.hpos  <= HCW'(wd);
        IW'(3):  begin cfg.hwid <= wd[3:0]; cfg.vwid <= wd[7:4]; end
        IW'(4):  cfg.vtot  <= RCW'(wd);
        IW'(5):  cfg.vdisp <= RCW'(wd);
        IW'(6):  cfg.vpos  <= RCW'(wd);
        IW'(7):  cfg.maxsc <= SCW'(wd);
        IW'(8):  cfg.vadj  <= SCW'(wd);
        IW'(9):  cfg.start[7:0] <= wd;
        IW'(10): cfg.start[AW-1:8] <= wd[AW-9:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmg_horiz.sv
module tmg_horiz
  import tmg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  tmg_cfg_t       cfg,
  output logic [HCW-1:0] col,
  output logic           line_end,
  output logic           hsync_q
);
  assign line_end = (col >= cfg.htot);

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      hsync_q <= 1'b0;
    end else if (ce) begin
      col     <= line_end ? '0 : col + 1'b1;
      hsync_q <= in_window(col, cfg.hpos, cfg.hwid);
    end
  end
endmodule

// File: rtl/tmg_vert.sv
module tmg_vert
  import tmg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           line_end,
  input  tmg_cfg_t       cfg,
  output logic [RCW-1:0] row,
  output logic [SCW-1:0] scan,
  output logic           in_adj,
  output logic           vsync_q,
  output logic           frame_q
);
  logic [RCW-1:0] row_n;
  logic [SCW-1:0] scan_n;
  logic           adj_n;
  logic           vs_load;
  logic [3:0]     vs_cnt;

  always_comb begin
    row_n  = row;
    scan_n = scan + 1'b1;
    adj_n  = in_adj;
    if (in_adj) begin
      if ({1'b0, scan} + 1'b1 >= {1'b0, cfg.vadj}) begin
        row_n  = '0;
        scan_n = '0;
        adj_n  = 1'b0;
      end
    end else if (scan >= cfg.maxsc) begin
      scan_n = '0;
      if (row >= cfg.vtot) begin
        if (cfg.vadj == '0) row_n = '0;
        else                adj_n = 1'b1;
      end else begin
        row_n = row + 1'b1;
      end
    end
  end

  assign vs_load = !adj_n && (row_n == cfg.vpos) && (scan_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      row     <= '0;
      scan    <= '0;
      in_adj  <= 1'b0;
      vs_cnt  <= '0;
      vsync_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= ce && line_end && vs_load && (cfg.vwid != '0);
      if (ce && line_end) begin
        row    <= row_n;
        scan   <= scan_n;
        in_adj <= adj_n;
        if (vs_load) begin
          vs_cnt  <= cfg.vwid;
          vsync_q <= (cfg.vwid != '0);
        end else if (vs_cnt != '0) begin
          vs_cnt  <= vs_cnt - 1'b1;
          vsync_q <= (vs_cnt > 4'd1);
        end
      end
    end
  end
endmodule

// File: rtl/tmg_crt_timing.sv
module tmg_crt_timing
  import tmg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           reg_we,
  input  logic [IW-1:0]  reg_idx,
  input  logic [7:0]     reg_wd,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           frame_o,
  output logic [RCW-1:0] row_o,
  output logic [SCW-1:0] scan_o,
  output logic [AW-1:0]  addr_o
);
  tmg_cfg_t       cfg;
  logic [HCW-1:0] col;
  logic           line_end;
  logic           in_adj;
  logic           de_q;

  tmg_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wd(reg_wd), .cfg(cfg)
  );

  tmg_horiz u_h (
    .clk(clk), .rst(rst), .ce(ce), .cfg(cfg),
    .col(col), .line_end(line_end), .hsync_q(hsync_o)
  );

  tmg_vert u_v (
    .clk(clk), .rst(rst), .ce(ce), .line_end(line_end), .cfg(cfg),
    .row(row_o), .scan(scan_o), .in_adj(in_adj),
    .vsync_q(vsync_o), .frame_q(frame_o)
  );

  always_ff @(posedge clk) begin
    if (rst)     de_q <= 1'b0;
    else if (ce) de_q <= (col < cfg.hdisp) && (row_o < cfg.vdisp) && !in_adj;
  end

  assign de_o   = de_q;
  assign addr_o = refresh_addr(cfg.start, row_o, cfg.hdisp, col);
endmodule

// File: rtl/tmg_crt_timing_chk.sv
module tmg_crt_timing_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       reg_we,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic       de_o,
  input logic       frame_o,
  input logic [6:0] row_o,
  input logic [4:0] scan_o,
  input logic [9:0] addr_o,
  input logic       line_end,
  input logic       in_adj
);
  // R8
  frame_with_vsync_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> vsync_o);

  // R8
  frame_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable({hsync_o, vsync_o, de_o, row_o, scan_o}));

  // R5
  row_mid_line_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !line_end) |=> $stable({row_o, scan_o}));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !reg_we) |=> $stable(addr_o));

  // R4
  adj_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && in_adj) |=> !de_o);
endmodule

bind tmg_crt_timing tmg_crt_timing_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce), .reg_we(reg_we),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .frame_o(frame_o),
  .row_o(row_o), .scan_o(scan_o), .addr_o(addr_o),
  .line_end(line_end), .in_adj(in_adj)
);

// File: tb/tb_tmg_crt_timing.sv
`timescale 1ns/1ps
module tb_tmg_crt_timing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] reg_wd = '0;
  logic       hsync_o, vsync_o, de_o, frame_o;
  logic [6:0] row_o;
  logic [4:0] scan_o;
  logic [9:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmg_crt_timing dut (
    .clk(clk), .rst(rst), .ce(ce), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wd(reg_wd), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .frame_o(frame_o), .row_o(row_o), .scan_o(scan_o), .addr_o(addr_o)
  );

  // bench copy of the configuration
  int c_htot, c_hdisp, c_hpos, c_hw, c_vw, c_vtot, c_vdisp, c_vpos, c_max, c_vadj, c_start;
  // bench raster state
  int m_col, m_row, m_scan, m_vc;
  bit m_adj, m_hs, m_vs, m_de, m_fr;

  task automatic load_defaults();
    c_htot = 31; c_hdisp = 24; c_hpos = 26; c_hw = 4; c_vw = 3;
    c_vtot = 31; c_vdisp = 27; c_vpos = 28; c_max = 7; c_vadj = 1; c_start = 0;
    m_col = 0; m_row = 0; m_scan = 0; m_vc = 0;
    m_adj = 0; m_hs = 0; m_vs = 0; m_de = 0; m_fr = 0;
  endtask

  function automatic int exp_addr();
    return (c_start + m_row * c_hdisp + m_col) % 1024;
  endfunction

  task automatic model_write(input int idx, input int v);
    case (idx)
      0: c_htot = v;   1: c_hdisp = v;  2: c_hpos = v;
      3: begin c_hw = v % 16; c_vw = v / 16; end
      4: c_vtot = v % 128; 5: c_vdisp = v % 128; 6: c_vpos = v % 128;
      7: c_max = v % 32;   8: c_vadj = v % 32;
      9: c_start = (c_start / 256) * 256 + v;
      10: c_start = (c_start % 256) + (v % 4) * 256;
      default: ;
    endcase
  endtask

  task automatic model_step(input bit c);
    bit le, an, ld;
    int rn, sn;
    m_fr = 0;
    if (!c) return;
    le = (m_col >= c_htot);
    m_hs = (m_col >= c_hpos) && (m_col < c_hpos + c_hw);
    m_de = (m_col < c_hdisp) && (m_row < c_vdisp) && !m_adj;
    m_col = le ? 0 : (m_col + 1) % 256;
    if (le) begin
      rn = m_row; sn = (m_scan + 1) % 32; an = m_adj;
      if (m_adj) begin
        if (m_scan + 1 >= c_vadj) begin rn = 0; sn = 0; an = 0; end
      end else if (m_scan >= c_max) begin
        sn = 0;
        if (m_row >= c_vtot) begin
          if (c_vadj == 0) rn = 0; else an = 1;
        end else rn = (m_row + 1) % 128;
      end
      ld = !an && (rn == c_vpos) && (sn == 0);
      if (ld) begin m_vc = c_vw; m_fr = (c_vw != 0); end
      else if (m_vc != 0) m_vc--;
      m_vs = (m_vc != 0);
      m_row = rn; m_scan = sn; m_adj = an;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk({"R3 hsync ", ctx}, hsync_o, m_hs);
    chk({"R7 vsync ", ctx}, vsync_o, m_vs);
    chk({"R4 de ", ctx}, de_o, m_de);
    chk({"R8 frame ", ctx}, frame_o, m_fr);
    chk({"R5 R6 row ", ctx}, row_o, m_row);
    chk({"R5 R6 scan ", ctx}, scan_o, m_scan);
    chk({"R9 addr ", ctx}, addr_o, exp_addr());
  endtask

  // one clock: compare at negedge, drive, then advance the model past the edge
  task automatic cycle(input bit c, input bit w, input int idx, input int v, input string ctx);
    @(negedge clk);
    compare_all(ctx);
    ce = c; reg_we = w; reg_idx = 4'(idx); reg_wd = 8'(v);
    model_step(c);
    if (w) model_write(idx, v);
  endtask

  task automatic run(input int n, input int pct, input string ctx);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < pct, 1'b0, 0, 0, ctx);
  endtask

  initial begin
    int frames;
    void'($urandom(32'd4711));
    load_defaults();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 hsync in reset", hsync_o, 0);
    chk("R1 vsync in reset", vsync_o, 0);
    chk("R1 de in reset", de_o, 0);
    chk("R1 frame in reset", frame_o, 0);
    chk("R1 row in reset", row_o, 0);
    chk("R1 scan in reset", scan_o, 0);
    chk("R1 addr in reset", addr_o, 0);
    rst = 1'b0;
    model_step(0);

    // power-up geometry, a bit over one full frame (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    run(12000, 75, "defaults");

    // R2 stall: ce low for a stretch, everything holds
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 0, 0, "R2 stall");

    // R11 lower the line total under the live column
    while (m_col < 20) cycle(1'b1, 1'b0, 0, 0, "R11 approach");
    cycle(1'b1, 1'b1, 0, 5, "R11 write");
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, 0, 0, "R11 wrap");

    // R10 small geometry written while running, start address near the top for wrap
    cycle(1'b1, 1'b1, 0, 9,    "R10 wr");
    cycle(1'b0, 1'b1, 1, 6,    "R10 wr");
    cycle(1'b1, 1'b1, 2, 7,    "R10 wr");
    cycle(1'b1, 1'b1, 3, 8'h21, "R10 wr");
    cycle(1'b0, 1'b1, 4, 5,    "R10 wr");
    cycle(1'b1, 1'b1, 5, 4,    "R10 wr");
    cycle(1'b1, 1'b1, 6, 4,    "R10 wr");
    cycle(1'b1, 1'b1, 7, 2,    "R10 wr");
    cycle(1'b1, 1'b1, 8, 2,    "R10 wr");
    cycle(1'b1, 1'b1, 9, 8'hF0, "R10 wr");
    cycle(1'b1, 1'b1, 10, 3,   "R10 wr");
    // R10 spare indices have no effect
    for (int k = 11; k < 16; k++) cycle(1'b1, 1'b1, k, 8'h00, "R10 spare idx");
    frames = 0;
    for (int i = 0; i < 2500; i++) begin
      cycle(($urandom % 100) < 70, 1'b0, 0, 0, "small geometry");
      if (m_fr) frames++;
    end
    // R8 several vsync starts seen
    checks++;
    if (frames < 5) begin
      errors++;
      $display("FAIL R8 frame pulses actual=%0d expected>=5", frames);
    end

    // R6 no adjust lines, R3 R7 widths of zero
    cycle(1'b1, 1'b1, 8, 0, "R6 vadj0");
    cycle(1'b1, 1'b1, 3, 8'h00, "R3 R7 width0");
    run(1500, 80, "vadj0 width0");
    cycle(1'b1, 1'b1, 3, 8'h32, "R7 width");
    cycle(1'b1, 1'b1, 6, 0, "R7 vpos0");
    run(1500, 90, "vpos0");
    cycle(1'b0, 1'b0, 0, 0, "final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule